// File: doc/BRIEF.md
# Windowed Field Statistics Collector

This block watches a 4:2:2 YUV pixel stream and, for every field, gathers four figures over a rectangular window that the host programs: the brightest luma sample, the total of the luma samples, the total of the blue-difference chroma samples and the total of the red-difference chroma samples. Only pixels whose column and line fall inside the window contribute. The block takes no action based on these figures. Exposure and white-balance decisions are made by host software, which reads the results once per field.

The block counts pixel positions itself. A field-start strobe resets the line and column counters. A line-end strobe advances the line and returns the column to zero. Each accepted pixel advances the column. The stream carries luma on one byte lane and chroma on the other, with Cb and Cr alternating by column. The working figures clear at field start. At field end they are copied into output registers that hold steady until the next field end, and a one-cycle done pulse marks each update.

Top module: `roi_stats`

## Requirements
- R1: A pixel contributes only if win_col_lo <= column <= win_col_hi and win_line_lo <= line <= win_line_hi (all bounds inclusive). When a low bound exceeds its high bound, the window is empty and no pixel contributes.
- R2: The column is 0 after field_start or line_end and rises by one for each accepted pixel. The line is 0 after field_start and rises by one for each line_end. Cycles with px_valid low do not advance the column.
- R3: stat_peak_y reports the largest luma sample that contributed in the field, or 0 if none contributed.
- R4: stat_sum_y reports the unsigned sum of the luma samples that contributed.
- R5: At an even column the chroma byte is Cb, and at an odd column it is Cr. Each is summed into stat_sum_cb or stat_sum_cr as the two's-complement value (byte - 128).
- R6: field_start clears the working peak and sums. A pixel presented in the same cycle as field_start, line_end or field_end is discarded and does not advance the column.
- R7: On a field_end cycle, the outputs take the working values accumulated before that cycle, and stat_done is high for exactly the following cycle. In all other cycles the outputs hold their values.
- R8: After reset, all statistics outputs are 0 and stat_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | Field start strobe |
| line_end | input | 1 | Line end strobe |
| field_end | input | 1 | Field end strobe, loads the outputs |
| px_valid | input | 1 | Pixel present this cycle |
| px_luma | input | PIX_W | Luma sample |
| px_chroma | input | PIX_W | Chroma sample, Cb at even column, Cr at odd column |
| win_col_lo | input | POS_W | First window column |
| win_col_hi | input | POS_W | Last window column |
| win_line_lo | input | POS_W | First window line |
| win_line_hi | input | POS_W | Last window line |
| stat_peak_y | output | PIX_W | Peak luma of the last field |
| stat_sum_y | output | ACC_W | Luma total of the last field |
| stat_sum_cb | output | ACC_W | Signed Cb total of the last field |
| stat_sum_cr | output | ACC_W | Signed Cr total of the last field |
| stat_done | output | 1 | One-cycle pulse after each output update |

## Verification
The bench builds the block with its default parameters: 8-bit samples and 11-bit positions, which give 30-bit totals. With these values the chroma extremes of -128 and +127 and a peak luma of 255 can be driven directly. The bench uses short fields of a few lines, so window edges at the first and last column and line are reached in a few cycles. Windows set to cover everything, to a single pixel, and to an empty range (low bound above high bound) are each compared every cycle against a behavioural model.

// File: rtl/roi_pkg.sv
package roi_pkg;

  typedef enum logic {PH_CB = 1'b0, PH_CR = 1'b1} chroma_phase_e;

  // inclusive range test on zero-extended positions
  function automatic logic in_span(input logic [15:0] v, input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/roi_position.sv
module roi_position
  import roi_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic             line_end,
  input  logic             field_end,
  input  logic             px_valid,
  input  logic [POS_W-1:0] col_lo,
  input  logic [POS_W-1:0] col_hi,
  input  logic [POS_W-1:0] line_lo,
  input  logic [POS_W-1:0] line_hi,
  output logic             take,
  output logic             in_win,
  output chroma_phase_e    phase
);

  logic [POS_W-1:0] col_q, line_q;

  assign take   = px_valid && !field_start && !line_end && !field_end;
  assign in_win = in_span(16'(col_q), 16'(col_lo), 16'(col_hi)) &&
                  in_span(16'(line_q), 16'(line_lo), 16'(line_hi));
  assign phase  = col_q[0] ? PH_CR : PH_CB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (field_start) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (line_end) begin
      col_q  <= '0;
      line_q <= line_q + 1'b1;
    end else if (take) begin
      col_q  <= col_q + 1'b1;
    end
  end

  // R2
  col_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start || line_end) |=> (col_q == '0));

  // R2
  line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (line_q == '0));

endmodule

// File: rtl/roi_accum.sv
module roi_accum
  import roi_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ACC_W = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    take,
  input  logic                    in_win,
  input  chroma_phase_e           phase,
  input  logic [PIX_W-1:0]        luma,
  input  logic [PIX_W-1:0]        chroma,
  output logic [PIX_W-1:0]        peak,
  output logic [ACC_W-1:0]        sum_y,
  output logic signed [ACC_W-1:0] sum_cb,
  output logic signed [ACC_W-1:0] sum_cr
);

  localparam int MID = 1 << (PIX_W - 1);

  // chroma byte minus mid-scale, sign-extended to accumulator width
  function automatic logic signed [ACC_W-1:0] chroma_off(input logic [PIX_W-1:0] c);
    logic signed [PIX_W:0] d;
    d = $signed({1'b0, c}) - $signed((PIX_W+1)'(MID));
    return ACC_W'(d);
  endfunction

  logic hit, hit_cb, hit_cr;
  assign hit    = take && in_win;
  assign hit_cb = hit && (phase == PH_CB);
  assign hit_cr = hit && (phase == PH_CR);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      peak   <= '0;
      sum_y  <= '0;
      sum_cb <= '0;
      sum_cr <= '0;
    end else begin
      if (hit && luma > peak) peak <= luma;
      if (hit)    sum_y  <= sum_y + ACC_W'(luma);
      if (hit_cb) sum_cb <= sum_cb + chroma_off(chroma);
      if (hit_cr) sum_cr <= sum_cr + chroma_off(chroma);
    end
  end

  // R3
  peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (peak >= $past(peak)));

  // R4
  sum_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (sum_y >= $past(sum_y)));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (peak == '0 && sum_y == '0 && sum_cb == '0 && sum_cr == '0));

endmodule

// File: rtl/roi_latch.sv
module roi_latch #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snap,
  input  logic [PIX_W-1:0]        w_peak,
  input  logic [ACC_W-1:0]        w_sum_y,
  input  logic signed [ACC_W-1:0] w_sum_cb,
  input  logic signed [ACC_W-1:0] w_sum_cr,
  output logic [PIX_W-1:0]        o_peak,
  output logic [ACC_W-1:0]        o_sum_y,
  output logic signed [ACC_W-1:0] o_sum_cb,
  output logic signed [ACC_W-1:0] o_sum_cr,
  output logic                    done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_peak   <= '0;
      o_sum_y  <= '0;
      o_sum_cb <= '0;
      o_sum_cr <= '0;
      done     <= 1'b0;
    end else begin
      done <= snap;
      if (snap) begin
        o_peak   <= w_peak;
        o_sum_y  <= w_sum_y;
        o_sum_cb <= w_sum_cb;
        o_sum_cr <= w_sum_cr;
      end
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> ($stable(o_peak) && $stable(o_sum_y) && $stable(o_sum_cb) && $stable(o_sum_cr)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(snap));

endmodule

// File: rtl/roi_stats.sv
module roi_stats
  import roi_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int POS_W = 11,
  localparam int ACC_W = PIX_W + 2 * POS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    field_start,
  input  logic                    line_end,
  input  logic                    field_end,
  input  logic                    px_valid,
  input  logic [PIX_W-1:0]        px_luma,
  input  logic [PIX_W-1:0]        px_chroma,
  input  logic [POS_W-1:0]        win_col_lo,
  input  logic [POS_W-1:0]        win_col_hi,
  input  logic [POS_W-1:0]        win_line_lo,
  input  logic [POS_W-1:0]        win_line_hi,
  output logic [PIX_W-1:0]        stat_peak_y,
  output logic [ACC_W-1:0]        stat_sum_y,
  output logic signed [ACC_W-1:0] stat_sum_cb,
  output logic signed [ACC_W-1:0] stat_sum_cr,
  output logic                    stat_done
);

  // named internal events
  logic          take_w, in_win_w;
  chroma_phase_e phase_w;
  logic [PIX_W-1:0]        w_peak;
  logic [ACC_W-1:0]        w_sum_y;
  logic signed [ACC_W-1:0] w_sum_cb, w_sum_cr;

  roi_position #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_end(line_end),
    .field_end(field_end), .px_valid(px_valid),
    .col_lo(win_col_lo), .col_hi(win_col_hi), .line_lo(win_line_lo), .line_hi(win_line_hi),
    .take(take_w), .in_win(in_win_w), .phase(phase_w)
  );

  roi_accum #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(field_start), .take(take_w), .in_win(in_win_w),
    .phase(phase_w), .luma(px_luma), .chroma(px_chroma),
    .peak(w_peak), .sum_y(w_sum_y), .sum_cb(w_sum_cb), .sum_cr(w_sum_cr)
  );

  roi_latch #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .snap(field_end),
    .w_peak(w_peak), .w_sum_y(w_sum_y), .w_sum_cb(w_sum_cb), .w_sum_cr(w_sum_cr),
    .o_peak(stat_peak_y), .o_sum_y(stat_sum_y), .o_sum_cb(stat_sum_cb),
    .o_sum_cr(stat_sum_cr), .done(stat_done)
  );

  // R6
  strobe_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && (line_end || field_end) && !field_start) |=>
      ($stable(w_sum_y) && $stable(w_sum_cb) && $stable(w_sum_cr)));

  // R7
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> stat_done);

endmodule

// File: tb/test_roi_stats.sv
module test_roi_stats;

  localparam int PW = 8;
  localparam int QW = 11;
  localparam int AW = PW + 2 * QW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 0, le = 0, fe = 0, pv = 0;
  logic [PW-1:0] py = 0, pc = 0;
  logic [QW-1:0] cl = 0, ch = 0, ll = 0, lh = 0;
  logic [PW-1:0] o_peak;
  logic [AW-1:0] o_sy;
  logic signed [AW-1:0] o_cb, o_cr;
  logic o_done;

  always #2.5 clk = ~clk;

  roi_stats #(.PIX_W(PW), .POS_W(QW)) i_roi_stats (
    .clk(clk), .rst_n(rst_n), .field_start(fs), .line_end(le), .field_end(fe),
    .px_valid(pv), .px_luma(py), .px_chroma(pc),
    .win_col_lo(cl), .win_col_hi(ch), .win_line_lo(ll), .win_line_hi(lh),
    .stat_peak_y(o_peak), .stat_sum_y(o_sy), .stat_sum_cb(o_cb), .stat_sum_cr(o_cr),
    .stat_done(o_done)
  );

  int checks = 0, fails = 0;
  string scen = "reset";

  // behavioural reference model
  int mcol = 0, mline = 0, mpeak = 0;
  longint msy = 0, mcb = 0, mcr = 0;
  int epeak = 0; longint esy = 0, ecb = 0, ecr = 0; int edone = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3 peak", longint'(o_peak), longint'(epeak));
    chk("R4 sum_y", longint'(o_sy), esy);
    chk("R5 sum_cb", longint'(o_cb), ecb);
    chk("R5 sum_cr", longint'(o_cr), ecr);
    chk("R7 done", longint'(o_done), longint'(edone));
  endtask

  function automatic bit inside_win(int c, int l);
    return (c >= int'(cl)) && (c <= int'(ch)) && (l >= int'(ll)) && (l <= int'(lh));
  endfunction

  task automatic model_edge();
    edone = 0;
    if (fe) begin
      epeak = mpeak; esy = msy; ecb = mcb; ecr = mcr; edone = 1;
    end
    if (fs) begin
      mpeak = 0; msy = 0; mcb = 0; mcr = 0; mcol = 0; mline = 0;
    end else if (le) begin
      mline++; mcol = 0;
    end else if (pv && !fe) begin
      if (inside_win(mcol, mline)) begin
        if (int'(py) > mpeak) mpeak = int'(py);
        msy += longint'(py);
        if (mcol % 2 == 0) mcb += longint'(pc) - 128;
        else               mcr += longint'(pc) - 128;
      end
      mcol++;
    end
  endtask

  task automatic cyc(bit v, int y, int c, bit s, bit l, bit e);
    @(negedge clk);
    compare_all();
    pv = v; py = PW'(y); pc = PW'(c); fs = s; le = l; fe = e;
    model_edge();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic rand_field(int lines, int ppl, bit gaps);
    cyc(0, 0, 0, 1, 0, 0);
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < ppl; p++) begin
        if (gaps && ($urandom % 3 == 0)) cyc(0, 0, 0, 0, 0, 0);
        cyc(1, int'($urandom % 256), int'($urandom % 256), 0, 0, 0);
      end
      cyc(0, 0, 0, 0, 1, 0);
    end
    cyc(0, 0, 0, 0, 0, 1);
    idle(2);
  endtask

  task automatic set_win(int a, int b, int c, int d);
    cl = QW'(a); ch = QW'(b); ll = QW'(c); lh = QW'(d);
  endtask

  int cyc_count = 0;
  bit timed_out = 0;
  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 100000 && !timed_out) begin
      timed_out = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc_count);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(17));
    set_win(0, 2047, 0, 2047);
    repeat (3) @(negedge clk);
    scen = "R8 reset";
    compare_all();
    rst_n = 1'b1;
    idle(2);

    scen = "R4 full window random";
    rand_field(4, 10, 0);

    scen = "R1 R2 sub-window with gaps";
    set_win(2, 5, 1, 2);
    rand_field(4, 8, 1);

    scen = "R1 single pixel at col 3 line 2";
    set_win(3, 3, 2, 2);
    rand_field(4, 6, 1);

    scen = "R1 empty window lo>hi";
    set_win(5, 4, 0, 10);
    rand_field(3, 8, 0);
    chk("R1 empty sum_y", longint'(o_sy), 0);

    scen = "R5 chroma extremes R3 peak 255";
    set_win(0, 2047, 0, 2047);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 255, 0, 0, 0, 0);    // Cb -128
    cyc(1, 10, 255, 0, 0, 0);   // Cr +127
    cyc(1, 0, 255, 0, 0, 0);    // Cb +127
    cyc(1, 3, 0, 0, 0, 0);      // Cr -128
    cyc(0, 0, 0, 0, 0, 1);
    idle(1);
    chk("R5 cb extreme", longint'(o_cb), -1);
    chk("R3 peak 255", longint'(o_peak), 255);

    scen = "R6 pixels on strobe cycles discarded";
    cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 200, 200, 1, 0, 0);
    cyc(1, 50, 140, 0, 0, 0);
    cyc(1, 220, 220, 0, 1, 0);
    cyc(1, 60, 100, 0, 0, 0);
    cyc(1, 240, 240, 0, 0, 1);
    idle(1);
    chk("R6 discard sum_y", longint'(o_sy), 110);

    scen = "R6 mid-field restart clears";
    rand_field(2, 5, 0);
    cyc(1, 90, 90, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 7, 129, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    idle(1);
    chk("R6 restart sum_y", longint'(o_sy), 7);

    scen = "R7 back-to-back field_end and hold";
    cyc(1, 30, 30, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    idle(20);
    rand_field(3, 12, 1);

    @(negedge clk);
    compare_all();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule